// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides, for a five-stage in-order integer pipeline, where each of the two ALU operands of the instruction now in execute should come from. The candidates are the register file, the result held after the memory stage, and the result just produced by the ALU. It also detects the single case that forwarding cannot cover: a load in execute whose destination is read by the instruction now in decode. When that happens it freezes fetch and decode for one cycle and turns the instruction entering execute into a bubble.

The unit is purely combinational. It sits beside the pipeline registers, reads register numbers and a few control flags from them, and drives the operand multiplexer selects and the hold and bubble controls. It keeps no state of its own.

Top module: `hz_ctrl_unit`

## Requirements
- R1: Each operand select is 2 bits: 2'b00 takes the register file, 2'b01 takes the memory/writeback result, 2'b10 takes the execute/memory result; 2'b11 is never produced.
- R2: An operand selects 2'b10 when the execute/memory write flag is set, its destination is nonzero and equals that operand's source (first source for `sel_a`, second source for `sel_b`).
- R3: An operand selects 2'b01 when the memory/writeback write flag is set, its destination is nonzero, equals the operand's source, and the R2 condition does not hold.
- R4: When both later stages write the same register an operand reads, the execute/memory result (2'b10) is chosen.
- R5: A destination of register 0 is never forwarded; a source of 0 always selects 2'b00.
- R6: A stall is raised when the instruction in execute is a load and its second source field (the load destination) equals either source of the instruction in decode.
- R7: `pc_hold`, `ifid_hold` and `ctl_zero` are all high during a stall and all low otherwise.
- R8: A load followed at once by a dependent AND, then OR, then ADD costs exactly one bubble; afterwards the AND takes its first operand from memory/writeback, and the OR and the ADD take their first operand from execute/memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register of the instruction in execute |
| ex_src_b | input | REG_W | Second source register of the instruction in execute; also the load destination |
| id_src_a | input | REG_W | First source register of the instruction in decode |
| id_src_b | input | REG_W | Second source register of the instruction in decode |
| exm_wr | input | 1 | Register write enable held in the execute/memory register |
| exm_rd | input | REG_W | Destination held in the execute/memory register |
| mwb_wr | input | 1 | Register write enable held in the memory/writeback register |
| mwb_rd | input | REG_W | Destination held in the memory/writeback register |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| sel_a | output | 2 | Select for the first ALU operand |
| sel_b | output | 2 | Select for the second ALU operand |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ctl_zero | output | 1 | Clear the control fields entering execute |

## Verification
The bench builds the unit with the default REG_W of 5, so register numbers span 0 to 31 as in a normal integer file. Random vectors draw register numbers from 0 to 3 only, so that equal numbers, register 0 and double matches occur in most draws, and both the priority rule and the zero suppression are hit many times. A small pipeline model in the bench replays the load-use sequence through real stage registers to confirm the single bubble and the later forwarding choices.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_select.sv
`timescale 1ns/1ps
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             mwb_wr,
  input  logic [REG_W-1:0] mwb_rd,
  output fwd_sel_e         sel
);
  logic exm_hit;
  logic mwb_hit;

  always_comb begin
    exm_hit = exm_wr && (exm_rd != '0) && (exm_rd == src);
    mwb_hit = mwb_wr && (mwb_rd != '0) && (mwb_rd == src);
    if (exm_hit)      sel = FWD_EXM;
    else if (mwb_hit) sel = FWD_MWB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
`timescale 1ns/1ps
module hz_load_use #(
  parameter int REG_W = 5
) (
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_ld_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  output logic             stall
);
  always_comb begin
    stall = ex_is_load && ((ex_ld_dst == id_src_a) || (ex_ld_dst == id_src_b));
  end
endmodule

// File: rtl/hz_ctrl_unit.sv
`timescale 1ns/1ps
module hz_ctrl_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             exm_wr,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             mwb_wr,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             ex_is_load,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ctl_zero
);
  logic [REG_W-1:0] op_src [NUM_OPS];
  fwd_sel_e         op_sel [NUM_OPS];
  logic             stall;

  assign op_src[0] = ex_src_a;
  assign op_src[1] = ex_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_select #(.REG_W(REG_W)) u_sel (
      .src    (op_src[g]),
      .exm_wr (exm_wr),
      .exm_rd (exm_rd),
      .mwb_wr (mwb_wr),
      .mwb_rd (mwb_rd),
      .sel    (op_sel[g])
    );

    always_comb begin
      AST_SEL_LEGAL: assert (op_sel[g] != 2'b11);                        // R1
      if (op_sel[g] != FWD_RF)
        AST_NO_ZERO_FWD: assert (op_src[g] != '0);                       // R5
      if (op_sel[g] == FWD_MWB)
        AST_MWB_MATCH: assert (mwb_wr && (mwb_rd == op_src[g]));         // R3
      if (op_sel[g] == FWD_EXM)
        AST_EXM_MATCH: assert (exm_wr && (exm_rd == op_src[g]));         // R2
      if (exm_wr && (exm_rd == op_src[g]) && (op_src[g] != '0))
        AST_EXM_WINS: assert (op_sel[g] == FWD_EXM);                     // R4
    end
  end

  hz_load_use #(.REG_W(REG_W)) u_lu (
    .ex_is_load (ex_is_load),
    .ex_ld_dst  (ex_src_b),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .stall      (stall)
  );

  assign sel_a     = op_sel[0];
  assign sel_b     = op_sel[1];
  assign pc_hold   = stall;
  assign ifid_hold = stall;
  assign ctl_zero  = stall;

  always_comb begin
    if (pc_hold)
      AST_STALL_NEEDS_LOAD: assert (ex_is_load);                         // R6
    AST_HOLD_ALIGN: assert ((pc_hold == ifid_hold) && (ifid_hold == ctl_zero)); // R7
  end
endmodule

// File: tb/tb_hz_ctrl_unit.sv
`timescale 1ns/1ps
module tb_hz_ctrl_unit;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [REG_W-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b, exm_rd, mwb_rd;
  logic             exm_wr, mwb_wr, ex_is_load;
  logic [1:0]       sel_a, sel_b;
  logic             pc_hold, ifid_hold, ctl_zero;

  hz_ctrl_unit #(.REG_W(REG_W)) dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .exm_wr(exm_wr), .exm_rd(exm_rd), .mwb_wr(mwb_wr), .mwb_rd(mwb_rd),
    .ex_is_load(ex_is_load), .sel_a(sel_a), .sel_b(sel_b),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ctl_zero(ctl_zero)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sel(input int src, input bit ew, input int erd,
                                 input bit mw, input int mrd);
    if (ew && erd != 0 && erd == src) return 2;
    if (mw && mrd != 0 && mrd == src) return 1;
    return 0;
  endfunction

  function automatic int exp_stall(input bit ld, input int dst, input int a, input int b);
    return (ld && (dst == a || dst == b)) ? 1 : 0;
  endfunction

  task automatic drive(input int xa, input int xb, input int da, input int db,
                       input bit ew, input int erd, input bit mw, input int mrd, input bit ld);
    ex_src_a = REG_W'(xa); ex_src_b = REG_W'(xb);
    id_src_a = REG_W'(da); id_src_b = REG_W'(db);
    exm_wr = ew; exm_rd = REG_W'(erd); mwb_wr = mw; mwb_rd = REG_W'(mrd);
    ex_is_load = ld;
  endtask

  task automatic check_all(input string tag);
    int es;
    es = exp_stall(ex_is_load, int'(ex_src_b), int'(id_src_a), int'(id_src_b));
    chk({tag, " R2/R3 sel_a"}, int'(sel_a),
        exp_sel(int'(ex_src_a), exm_wr, int'(exm_rd), mwb_wr, int'(mwb_rd)));
    chk({tag, " R2/R3 sel_b"}, int'(sel_b),
        exp_sel(int'(ex_src_b), exm_wr, int'(exm_rd), mwb_wr, int'(mwb_rd)));
    chk({tag, " R6 pc_hold"}, int'(pc_hold), es);
    chk({tag, " R7 ifid_hold"}, int'(ifid_hold), es);
    chk({tag, " R7 ctl_zero"}, int'(ctl_zero), es);
  endtask

  // pipeline model for R8: fields rs, rt, rd, we, ld per stage
  int p_rs[4], p_rt[4], p_rd[4];
  bit p_we[4], p_ld[4];
  int if_rs, if_rt, if_rd; bit if_we, if_ld;
  int id_rs, id_rt, id_rd; bit id_we, id_ld;
  int ex_rs, ex_rt, ex_rd; bit ex_we, ex_ld;
  int em_rd; bit em_we;
  int mw_rd; bit mw_we;
  int pc;
  int bubbles;

  task automatic pipe_drive();
    drive(ex_rs, ex_rt, id_rs, id_rt, em_we, em_rd, mw_we, mw_rd, ex_ld);
  endtask

  task automatic pipe_step();
    bit st;
    st = pc_hold;
    @(posedge clk);
    mw_rd = em_rd; mw_we = em_we;
    em_rd = ex_rd; em_we = ex_we;
    if (st) begin
      bubbles++;
      ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_we = 0; ex_ld = 0;
    end else begin
      ex_rs = id_rs; ex_rt = id_rt; ex_rd = id_rd; ex_we = id_we; ex_ld = id_ld;
      if (pc < 4) begin
        id_rs = p_rs[pc]; id_rt = p_rt[pc]; id_rd = p_rd[pc]; id_we = p_we[pc]; id_ld = p_ld[pc];
      end else begin
        id_rs = 0; id_rt = 0; id_rd = 0; id_we = 0; id_ld = 0;
      end
      pc++;
    end
    pipe_drive();
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // idle state: all zero inputs
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R1 idle sel_a", int'(sel_a), 0);
    chk("R1 idle sel_b", int'(sel_b), 0);
    chk("R7 idle hold", int'(pc_hold | ifid_hold | ctl_zero), 0);

    // directed corners
    @(negedge clk); drive(3, 7, 0, 0, 1, 3, 1, 7, 0); #1;
    chk("R2 exm to a", int'(sel_a), 2);
    chk("R3 mwb to b", int'(sel_b), 1);
    @(negedge clk); drive(6, 6, 0, 0, 1, 6, 1, 6, 0); #1;
    chk("R4 priority a", int'(sel_a), 2);
    chk("R4 priority b", int'(sel_b), 2);
    @(negedge clk); drive(0, 0, 0, 0, 1, 0, 1, 0, 0); #1;
    chk("R5 zero dst a", int'(sel_a), 0);
    chk("R5 zero dst b", int'(sel_b), 0);
    @(negedge clk); drive(9, 9, 0, 0, 0, 9, 0, 9, 0); #1;
    chk("R2 no write flag", int'(sel_a), 0);
    @(negedge clk); drive(1, 4, 8, 4, 0, 0, 0, 0, 1); #1;
    chk("R6 load-use on b", int'(pc_hold), 1);
    chk("R7 all hold", int'(ifid_hold & ctl_zero), 1);
    @(negedge clk); drive(1, 4, 8, 4, 0, 0, 0, 0, 0); #1;
    chk("R6 not a load", int'(pc_hold), 0);
    @(negedge clk); drive(1, 4, 4, 2, 0, 0, 0, 0, 1); #1;
    chk("R6 load-use on a", int'(pc_hold), 1);
    @(negedge clk); drive(1, 4, 5, 2, 0, 0, 0, 0, 1); #1;
    chk("R6 load no match", int'(pc_hold), 0);

    // random vectors, register numbers 0..3
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      drive($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3),
            1'($urandom_range(1)), $urandom_range(3), 1'($urandom_range(1)),
            $urandom_range(3), 1'($urandom_range(1)));
      #1;
      check_all("rand");
    end

    // R8 sequence: load r2; and r4=r2,r5; or r4=r4,r2; add r9=r4,r2
    p_rs = '{1, 2, 4, 4}; p_rt = '{2, 5, 2, 2}; p_rd = '{2, 4, 4, 9};
    p_we = '{1, 1, 1, 1}; p_ld = '{1, 0, 0, 0};
    if_rs = 0; if_rt = 0; if_rd = 0; if_we = 0; if_ld = 0;
    id_rs = 0; id_rt = 0; id_rd = 0; id_we = 0; id_ld = 0;
    ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_we = 0; ex_ld = 0;
    em_rd = 0; em_we = 0; mw_rd = 0; mw_we = 0; pc = 0; bubbles = 0;
    @(negedge clk); pipe_drive(); #1;
    pipe_step();                 // load in decode
    pipe_step();                 // load in execute, AND in decode
    chk("R8 stall on and", int'(pc_hold), 1);
    pipe_step();                 // bubble in execute
    chk("R8 single stall", int'(pc_hold), 0);
    pipe_step();                 // AND in execute
    chk("R8 and sel_a mwb", int'(sel_a), 1);
    chk("R8 and sel_b rf", int'(sel_b), 0);
    pipe_step();                 // OR in execute
    chk("R8 or sel_a exm", int'(sel_a), 2);
    chk("R8 or sel_b rf", int'(sel_b), 0);
    pipe_step();                 // ADD in execute
    chk("R8 add sel_a exm", int'(sel_a), 2);
    chk("R8 add sel_b rf", int'(sel_b), 0);
    pipe_step();
    pipe_step();
    chk("R8 bubble count", bubbles, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule